// File: doc/BRIEF.md
# System Counter with Compare Interrupt

The block is a free-running 64-bit time base with one compare frame. It sits on a plain 32-bit register bus with an address, a write strobe, write data and read data. The counter advances once every three cycles of the base clock and starts at zero when reset is released. No enable bit gates it. Software reads the two halves of the count separately. Each half returns its live value, so software gets a coherent 64-bit value by reading high, then low, then high again, and retrying if the two high reads differ.

The compare frame holds a 52-bit compare value, split into a full low word and a 20-bit high word, and a control word. The control word carries an arm bit, an interrupt-unmask bit and a read-only match flag. While the frame is armed and the count is at or past the compare value, the match flag sets. The interrupt output is that flag gated by the unmask bit. The only way to acknowledge an event is to drop the arm bit, which clears the flag and removes the interrupt.

Top module: `syscnt_cmp_timer`

## Requirements
- R1: After reset the count is zero. It then advances by exactly one on every third rising clock edge, so after n edges with reset released it equals floor(n/3).
- R2: A read at offset 0x8 returns bits [31:0] of the live count, and a read at offset 0xC returns bits [63:32]. Neither half is latched by reading the other.
- R3: The compare low word is at 0x10020, the compare high word at 0x10024 and the control word at 0x1002C. After reset they read 0xFFFFFFFF, 0x000FFFFF and 0x00000000.
- R4: Only bits [19:0] of the compare high word are stored. Bits written above them are dropped and read back as zero.
- R5: Control bit 0 is arm and bit 1 is unmask. Bit 2 is the match flag. The flag sets on the first rising edge at which arm is 1 and the count is greater than or equal to the compare value, and it stays set while arm remains 1.
- R6: Writing arm to 0 clears the match flag on the next edge, and the interrupt one edge later. Writes to bit 2 have no effect.
- R7: The interrupt output is a register that follows the match flag AND the unmask bit one edge later. With unmask at 0 it stays low even while the flag is set.
- R8: The count words cannot be written. Reads of any unmapped offset return zero, and writes to unmapped offsets change no register.
- R9: While arm is 0 the match flag never sets, even with the count past the compare value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 20 | Byte offset of the register access |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq | output | 1 | Level interrupt, match flag AND unmask, registered |

## Verification
The bench tracks rising edges since reset and predicts every count read as one third of that number. A prescaler that is off by one, or a counter that latches its halves, shows up as a wrong low word. A compare is armed at least 0xFF ticks ahead and the bench checks that neither the flag nor the interrupt appears early. It then checks that both appear after the match, and that the interrupt stays low while unmask is 0. The bench drops arm to check acknowledgement, then tries to set the flag by a write and waits with the count past the compare while disarmed. A design that latched the flag, let it be written or let it set while disarmed would read back a nonzero bit 2. Writes to the count words, to unmapped offsets and above bit 19 of the compare high word are followed by read-backs that would reveal any leak.

// File: rtl/syscnt_pkg.sv
package syscnt_pkg;
   localparam int unsigned ADDR_W      = 20;
   localparam int unsigned BUS_W       = 32;
   localparam logic [ADDR_W-1:0] OFS_CNT_LO  = 20'h0_0008;
   localparam logic [ADDR_W-1:0] OFS_CNT_HI  = 20'h0_000C;
   localparam logic [ADDR_W-1:0] FRAME_BASE  = 20'h1_0000;
   localparam logic [ADDR_W-1:0] OFS_CMP_LO  = FRAME_BASE + 20'h20;
   localparam logic [ADDR_W-1:0] OFS_CMP_HI  = FRAME_BASE + 20'h24;
   localparam logic [ADDR_W-1:0] OFS_CTRL    = FRAME_BASE + 20'h2C;
   // control word bit positions
   localparam int unsigned CTRL_ARM    = 0;
   localparam int unsigned CTRL_UNMASK = 1;
   localparam int unsigned CTRL_FLAG   = 2;

   typedef struct packed {
      logic unmask;
      logic arm;
   } cmp_ctrl_t;
endpackage

// File: rtl/syscnt_prescaler.sv
module syscnt_prescaler #(
   parameter int unsigned DIV = 3
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);
   generate
      if (DIV < 1) begin : g_bad
         $error("syscnt_prescaler: DIV must be at least 1");
      end else if (DIV == 1) begin : g_pass
         assign tick = 1'b1;
      end else begin : g_div
         localparam int unsigned DIV_W = $clog2(DIV);
         logic [DIV_W-1:0] phase_q;

         assign tick = (phase_q == DIV_W'(DIV - 1));

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    phase_q <= '0;
            else if (tick) phase_q <= '0;
            else           phase_q <= phase_q + DIV_W'(1);
         end

         // R1: a tick is never followed directly by another tick
         assert_tick_spacing_R1: assert property (@(posedge clk) disable iff (!rst_n)
            tick |=> !tick);
      end
   endgenerate
endmodule

// File: rtl/syscnt_counter.sv
module syscnt_counter #(
   parameter int unsigned CNT_W = 64
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   output logic [CNT_W-1:0] count
);
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt_q <= '0;
      else if (tick) cnt_q <= cnt_q + CNT_W'(1);
   end

   assign count = cnt_q;

   assert_hold_no_tick_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(cnt_q));
   assert_step_on_tick_R1: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> cnt_q == $past(cnt_q) + CNT_W'(1));
endmodule

// File: rtl/syscnt_compare.sv
module syscnt_compare
   import syscnt_pkg::*;
#(
   parameter int unsigned CNT_W       = 64,
   parameter int unsigned HI_BITS     = 20
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] count,
   input  logic             wr_lo,
   input  logic             wr_hi,
   input  logic             wr_ctrl,
   input  logic [BUS_W-1:0] wdata,
   output logic [BUS_W-1:0] cmp_lo_rd,
   output logic [BUS_W-1:0] cmp_hi_rd,
   output logic [BUS_W-1:0] ctrl_rd,
   output logic             irq_o
);
   localparam int unsigned CMP_W = BUS_W + HI_BITS;

   generate
      if (HI_BITS < 1 || HI_BITS > BUS_W || CMP_W > CNT_W) begin : g_bad
         $error("syscnt_compare: HI_BITS out of range");
      end
   endgenerate

   logic [BUS_W-1:0]   lo_q;
   logic [HI_BITS-1:0] hi_q;
   cmp_ctrl_t          ctrl_q;
   logic               flag_q;
   logic               irq_q;
   logic               reached;

   assign reached = (count >= CNT_W'({hi_q, lo_q}));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lo_q   <= '1;
         hi_q   <= '1;
         ctrl_q <= '0;
      end else begin
         if (wr_lo)   lo_q   <= wdata;
         if (wr_hi)   hi_q   <= wdata[HI_BITS-1:0];
         if (wr_ctrl) ctrl_q <= '{unmask: wdata[CTRL_UNMASK], arm: wdata[CTRL_ARM]};
      end
   end

   // match flag: cleared only by disarming, never written by the bus
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           flag_q <= 1'b0;
      else if (!ctrl_q.arm) flag_q <= 1'b0;
      else if (reached)     flag_q <= 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_q <= 1'b0;
      else        irq_q <= flag_q & ctrl_q.unmask;
   end

   assign cmp_lo_rd = lo_q;
   assign cmp_hi_rd = BUS_W'(hi_q);
   assign ctrl_rd   = BUS_W'({flag_q, ctrl_q.unmask, ctrl_q.arm});
   assign irq_o     = irq_q;

   assert_flag_needs_arm_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag_q) |-> $past(ctrl_q.arm) && $past(reached));
   assert_flag_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q && ctrl_q.arm) |=> flag_q);
   assert_disarm_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl_q.arm |=> !flag_q);
   assert_irq_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
      irq_q |-> $past(flag_q) && $past(ctrl_q.unmask));
endmodule

// File: rtl/syscnt_cmp_timer.sv
module syscnt_cmp_timer
   import syscnt_pkg::*;
#(
   parameter int unsigned CNT_W   = 64,
   parameter int unsigned DIV     = 3,
   parameter int unsigned HI_BITS = 20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [BUS_W-1:0]  bus_wdata,
   output logic [BUS_W-1:0]  bus_rdata,
   output logic              irq
);
   generate
      if (CNT_W != 2 * BUS_W) begin : g_bad
         $error("syscnt_cmp_timer: CNT_W must be two bus words");
      end
   endgenerate

   logic             tick;
   logic [CNT_W-1:0] count;
   logic [BUS_W-1:0] cmp_lo_rd, cmp_hi_rd, ctrl_rd;
   logic             sel_lo, sel_hi, sel_ctrl;

   assign sel_lo   = (bus_addr == OFS_CMP_LO);
   assign sel_hi   = (bus_addr == OFS_CMP_HI);
   assign sel_ctrl = (bus_addr == OFS_CTRL);

   syscnt_prescaler #(.DIV(DIV)) i_presc (
      .clk (clk), .rst_n (rst_n), .tick (tick)
   );

   syscnt_counter #(.CNT_W(CNT_W)) i_cnt (
      .clk (clk), .rst_n (rst_n), .tick (tick), .count (count)
   );

   syscnt_compare #(.CNT_W(CNT_W), .HI_BITS(HI_BITS)) i_cmp (
      .clk       (clk),
      .rst_n     (rst_n),
      .count     (count),
      .wr_lo     (bus_wr && sel_lo),
      .wr_hi     (bus_wr && sel_hi),
      .wr_ctrl   (bus_wr && sel_ctrl),
      .wdata     (bus_wdata),
      .cmp_lo_rd (cmp_lo_rd),
      .cmp_hi_rd (cmp_hi_rd),
      .ctrl_rd   (ctrl_rd),
      .irq_o     (irq)
   );

   always_comb begin
      bus_rdata = '0;
      unique case (bus_addr)
         OFS_CNT_LO: bus_rdata = count[BUS_W-1:0];
         OFS_CNT_HI: bus_rdata = count[CNT_W-1:BUS_W];
         OFS_CMP_LO: bus_rdata = cmp_lo_rd;
         OFS_CMP_HI: bus_rdata = cmp_hi_rd;
         OFS_CTRL:   bus_rdata = ctrl_rd;
         default:    bus_rdata = '0;
      endcase
   end
endmodule

// File: tb/test_syscnt_cmp_timer.sv
`timescale 1ns/1ps
module test_syscnt_cmp_timer;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [19:0] bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq;

   always #2 clk = ~clk;   // 250 MHz

   syscnt_cmp_timer i_syscnt_cmp_timer (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
   );

   typedef struct { bit is_irq; logic [19:0] addr; logic [31:0] exp; string tag; } exp_t;
   exp_t        sb[$];
   int          checks = 0, errors = 0;
   int unsigned cyc = 0;
   bit          done = 0;

   always @(posedge clk) if (rst_n) cyc <= cyc + 1;

   function automatic logic [31:0] cnt_now();
      return 32'(cyc / 3);
   endfunction

   // driver side
   task automatic expect_rd(input logic [19:0] a, input logic [31:0] e, input string tag);
      exp_t it;
      @(negedge clk);
      bus_addr = a;
      it.is_irq = 0; it.addr = a; it.exp = e; it.tag = tag;
      sb.push_back(it);
   endtask

   task automatic expect_cnt(input logic [19:0] a, input string tag);
      exp_t it;
      @(negedge clk);
      bus_addr = a;
      it.is_irq = 0; it.addr = a; it.tag = tag;
      it.exp = (a == 20'h8) ? cnt_now() : 32'h0;
      sb.push_back(it);
   endtask

   task automatic expect_irq(input logic e, input string tag);
      exp_t it;
      @(negedge clk);
      it.is_irq = 1; it.addr = '0; it.exp = {31'b0, e}; it.tag = tag;
      sb.push_back(it);
   endtask

   task automatic wr(input logic [19:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic wait_count(input logic [31:0] target);
      while (cnt_now() < target) @(negedge clk);
      repeat (3) @(negedge clk);
   endtask

   // monitor side
   initial begin
      forever begin
         @(negedge clk);
         #1;
         while (sb.size() > 0) begin
            exp_t it;
            logic [31:0] act;
            it  = sb.pop_front();
            act = it.is_irq ? {31'b0, irq} : bus_rdata;
            checks++;
            if (act !== it.exp) begin
               errors++;
               $display("FAIL %s addr=%h actual=%h expected=%h", it.tag, it.addr, act, it.exp);
            end
         end
      end
   end

   initial begin
      #(200000 * 4);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      logic [31:0] tgt;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // reset state
      expect_rd(20'h10020, 32'hFFFF_FFFF, "R3 cmp lo reset");
      expect_rd(20'h10024, 32'h000F_FFFF, "R3 cmp hi reset");
      expect_rd(20'h1002C, 32'h0,         "R3 ctrl reset");
      expect_irq(1'b0, "R7 irq reset");
      expect_cnt(20'h8, "R1 count after reset");
      // rate over several phases
      for (int i = 0; i < 5; i++) begin
         repeat (7 + i) @(negedge clk);
         expect_cnt(20'h8, "R1 divide-by-three rate");
      end
      expect_rd(20'hC, 32'h0, "R2 high half");
      repeat (40) @(negedge clk);
      expect_cnt(20'h8, "R2 live low half");
      // read-only counters, unmapped offsets
      wr(20'h8, 32'h1234_5678);
      wr(20'hC, 32'hFFFF_FFFF);
      expect_cnt(20'h8, "R8 count write ignored lo");
      expect_rd(20'hC, 32'h0, "R8 count write ignored hi");
      wr(20'h10028, 32'h0);
      wr(20'h10030, 32'h3);
      expect_rd(20'h10028, 32'h0,         "R8 unmapped read");
      expect_rd(20'h4,     32'h0,         "R8 unmapped read low");
      expect_rd(20'h10020, 32'hFFFF_FFFF, "R8 unmapped write no effect");
      expect_rd(20'h1002C, 32'h0,         "R8 unmapped write ctrl");
      // high word width
      wr(20'h10024, 32'hFFFF_FFFF);
      expect_rd(20'h10024, 32'h000F_FFFF, "R4 high word masked");
      wr(20'h10024, 32'hABC0_0005);
      expect_rd(20'h10024, 32'h0000_0005, "R4 upper bits dropped");
      // compare, masked
      wr(20'h10024, 32'h0);
      tgt = cnt_now() + 32'h100;
      wr(20'h10020, tgt);
      wr(20'h1002C, 32'h1);
      expect_rd(20'h1002C, 32'h1, "R5 no early flag");
      wait_count(tgt);
      expect_rd(20'h1002C, 32'h5, "R5 flag set on match");
      expect_irq(1'b0, "R7 masked irq low");
      repeat (5) @(negedge clk);
      expect_rd(20'h1002C, 32'h5, "R5 flag sticky");
      // unmask
      wr(20'h1002C, 32'h3);
      repeat (2) @(negedge clk);
      expect_irq(1'b1, "R7 irq with unmask");
      expect_rd(20'h1002C, 32'h7, "R7 ctrl readback");
      // acknowledge
      wr(20'h1002C, 32'h2);
      repeat (2) @(negedge clk);
      expect_rd(20'h1002C, 32'h2, "R6 disarm clears flag");
      expect_irq(1'b0, "R6 irq dropped");
      repeat (10) @(negedge clk);
      expect_rd(20'h1002C, 32'h2, "R9 no flag while disarmed");
      wr(20'h1002C, 32'h4);
      repeat (2) @(negedge clk);
      expect_rd(20'h1002C, 32'h0, "R6 flag write ignored");
      // rearm while already past
      wr(20'h1002C, 32'h3);
      repeat (2) @(negedge clk);
      expect_rd(20'h1002C, 32'h7, "R5 greater-or-equal match");
      expect_irq(1'b1, "R7 irq on rearm");
      // second compare in future
      wr(20'h1002C, 32'h2);
      tgt = cnt_now() + 32'h200;
      wr(20'h10020, tgt);
      wr(20'h1002C, 32'h3);
      repeat (2) @(negedge clk);
      expect_irq(1'b0, "R7 no irq before match");
      expect_rd(20'h1002C, 32'h3, "R5 flag clear before match");
      wait_count(tgt);
      expect_irq(1'b1, "R7 irq after match");
      expect_cnt(20'h8, "R1 rate after long run");
      repeat (3) @(negedge clk);
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule